// File: doc/BRIEF.md
# Paged Write Cache with Flush Sequencer

This block gathers the data bytes of one write transaction into a 64-byte cache made of eight pages of eight bytes. When the bus transaction ends, it writes the cache to a nonvolatile array one page at a time. A write transaction opens with a start strobe that carries the byte address. Each data strobe then stores one byte at the running cache pointer. The first byte always goes into cache page 0, at the byte slot given by the low three bits of the start address. The pointer then steps through all 64 slots and wraps back to slot 0, so extra bytes overwrite earlier ones.

When the stop indication arrives, the flush sequencer visits cache pages 0 to 7 in order. For each page that holds at least one loaded byte, it raises a one-cycle page-write request. The request carries the array page address, the eight data bytes and a valid flag for each byte. The sequencer then waits for a fixed write-cycle time before it moves to the next page. Cache page k goes to the start address's array page plus k, modulo the number of array pages. Pages with no loaded byte take one cycle each and issue no request. While the flush runs, the busy flag is high and every input strobe is ignored.

Top module: `page_cache_committer`

## Requirements
- R1: After a start strobe with address A, loaded byte number i (counting from 0) lands in cache slot (A mod 8 + i) mod 64. Cache page k holds slots 8k to 8k+7. A later byte that reaches an occupied slot replaces the earlier one.
- R2: Cache page k is committed to array page ((A div 8) + k) mod 1024, and this address appears on `pg_addr`.
- R3: No request is raised and busy stays low until a stop strobe is sampled. When the cache holds loaded bytes, busy goes high on the clock edge that samples stop.
- R4: With a request, `pg_data` bits 8j+7..8j hold slot j of the page and `pg_valid` bit j is 1 exactly when that slot was loaded in the current transaction. These outputs change only on the cycle a request is raised.
- R5: Requests come out in ascending cache-page order, exactly one per page with at least one loaded byte. Empty pages are skipped. With WRITE_CYCLES = W and n non-empty pages, busy stays high for exactly 8 + n·W cycles.
- R6: A start strobe clears all valid flags, so bytes loaded before it in an unflushed transaction are never committed.
- R7: While busy is high, start, byte and stop strobes have no effect on the requests or data of the flush in progress.
- R8: A stop strobe with no loaded byte leaves busy low and raises no request.
- R9: Out of reset, busy and the request are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| txn_start | input | 1 | Opens a write transaction at `start_addr` |
| start_addr | input | 13 | Byte address of the first data byte |
| byte_wr | input | 1 | Stores `byte_data` at the cache pointer |
| byte_data | input | 8 | Data byte |
| stop | input | 1 | Ends the transaction and starts the commit |
| busy | output | 1 | High while the commit is in progress |
| pg_req | output | 1 | One-cycle page-write request |
| pg_addr | output | 10 | Array page address of the request |
| pg_data | output | 64 | Eight data bytes of the page, slot 0 in the low byte |
| pg_valid | output | 8 | Per-byte valid flags of the page |

## Verification
Two cases are hard to reach from the ports. The first is wrap-around overwrite from a non-aligned start: the final bytes land in page 0 and must replace the earliest bytes there. Only loads longer than 64 bytes, swept over every start offset, produce it. The second is a transaction that is reopened before any flush. The bench loads a full cache, sends a new start strobe without a stop, then loads one byte. Only the page of that one byte may be committed.

The bench drives strobes on every busy cycle of chosen flushes and checks that the data still matches. It places start pages just below 1024 so that the page address wraps.

// File: rtl/pcc_pkg.sv
// Package: shared types of the paged write cache.
// Assumes: nothing beyond standard SystemVerilog.
package pcc_pkg;

    // Flush sequencer phases.
    typedef enum logic [1:0] {
        FL_IDLE = 2'd0,
        FL_SCAN = 2'd1,
        FL_WAIT = 2'd2
    } flush_state_e;

endpackage

// File: rtl/pcc_store.sv
// Module: pcc_store
// Cache storage. It keeps a byte array with one valid flag per slot and a
// wrapping load pointer. It also gives a combinational read of one whole
// page, selected by page index.
// Assumes: PAGE_BYTES and NUM_PAGES are powers of two. A load start takes
// priority over a byte write in the same cycle. The caller gates every
// strobe while a flush runs.
module pcc_store #(
    parameter int PAGE_BYTES = 8,
    parameter int NUM_PAGES  = 8,
    parameter int DATA_W     = 8,
    localparam int OFF_W     = $clog2(PAGE_BYTES),
    localparam int IDX_W     = $clog2(NUM_PAGES),
    localparam int PTR_W     = OFF_W + IDX_W,
    localparam int SLOTS     = PAGE_BYTES * NUM_PAGES
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         ld_start,
    input  logic [OFF_W-1:0]             start_off,
    input  logic                         ld_byte,
    input  logic [DATA_W-1:0]            ld_data,
    input  logic                         clear_all,
    input  logic [IDX_W-1:0]             rd_idx,
    output logic [PAGE_BYTES*DATA_W-1:0] rd_data,
    output logic [PAGE_BYTES-1:0]        rd_valid,
    output logic                         any_valid
);

    logic [SLOTS-1:0][DATA_W-1:0] mem_q;
    logic [SLOTS-1:0]             val_q;
    logic [PTR_W-1:0]             ptr_q;

    // Pointer and valid flags: a start reloads the pointer and clears the
    // flags, and a byte marks its slot.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ptr_q <= '0;
            val_q <= '0;
        end else if (ld_start) begin
            ptr_q <= {{IDX_W{1'b0}}, start_off};
            val_q <= '0;
        end else if (clear_all) begin
            val_q <= '0;
        end else if (ld_byte) begin
            val_q[ptr_q] <= 1'b1;
            ptr_q        <= ptr_q + 1'b1;
        end
    end

    // Data array: no reset is needed because the valid flags qualify it.
    always_ff @(posedge clk) begin
        if (ld_byte && !ld_start) begin
            mem_q[ptr_q] <= ld_data;
        end
    end

    // Page read port: gathers the slots of the selected page.
    always_comb begin
        for (int j = 0; j < PAGE_BYTES; j++) begin
            rd_data[j*DATA_W +: DATA_W] = mem_q[{rd_idx, OFF_W'(j)}];
            rd_valid[j]                 = val_q[{rd_idx, OFF_W'(j)}];
        end
    end

    assign any_valid = |val_q;

endmodule

// File: rtl/pcc_flush_seq.sv
// Module: pcc_flush_seq
// Flush sequencer. It walks cache pages in ascending order and raises a
// one-cycle page-write request for each page with a loaded byte. It then
// waits WRITE_CYCLES clocks before it moves to the next page. An empty page
// costs one cycle.
// Assumes: WRITE_CYCLES >= 1. The page read data is combinational from the
// store for the index this module drives.
module pcc_flush_seq
    import pcc_pkg::*;
#(
    parameter int PAGE_BYTES   = 8,
    parameter int NUM_PAGES    = 8,
    parameter int DATA_W       = 8,
    parameter int PAGE_AW      = 10,
    parameter int WRITE_CYCLES = 16,
    localparam int IDX_W       = $clog2(NUM_PAGES),
    localparam int CNT_W       = $clog2(WRITE_CYCLES + 1)
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         flush_go,
    input  logic [PAGE_AW-1:0]           base_page,
    input  logic [PAGE_BYTES*DATA_W-1:0] page_data,
    input  logic [PAGE_BYTES-1:0]        page_valid,
    output logic [IDX_W-1:0]             idx,
    output logic                         busy,
    output logic                         flush_done,
    output logic                         pg_req,
    output logic [PAGE_AW-1:0]           pg_addr,
    output logic [PAGE_BYTES*DATA_W-1:0] pg_data,
    output logic [PAGE_BYTES-1:0]        pg_valid
);

    flush_state_e     state_q;
    logic [CNT_W-1:0] cnt_q;
    logic             advance;
    logic             last_idx;

    // Page step: leave the current page after a skip or an expired wait.
    assign advance    = (state_q == FL_SCAN && !(|page_valid)) ||
                        (state_q == FL_WAIT && cnt_q == '0);
    assign last_idx   = (idx == IDX_W'(NUM_PAGES - 1));
    assign flush_done = advance && last_idx;
    assign busy       = (state_q != FL_IDLE);

    // Sequencer state, write timer and the registered request outputs.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q  <= FL_IDLE;
            idx      <= '0;
            cnt_q    <= '0;
            pg_req   <= 1'b0;
            pg_addr  <= '0;
            pg_data  <= '0;
            pg_valid <= '0;
        end else begin
            pg_req <= 1'b0;
            case (state_q)
                FL_IDLE: begin
                    if (flush_go) begin
                        state_q <= FL_SCAN;
                        idx     <= '0;
                    end
                end
                FL_SCAN: begin
                    if (|page_valid) begin
                        pg_req   <= 1'b1;
                        pg_addr  <= base_page + PAGE_AW'(idx);
                        pg_data  <= page_data;
                        pg_valid <= page_valid;
                        cnt_q    <= CNT_W'(WRITE_CYCLES - 1);
                        state_q  <= FL_WAIT;
                    end
                end
                FL_WAIT: begin
                    if (cnt_q != '0) begin
                        cnt_q <= cnt_q - 1'b1;
                    end
                end
                default: state_q <= FL_IDLE;
            endcase
            if (advance) begin
                if (last_idx) begin
                    state_q <= FL_IDLE;
                end else begin
                    idx     <= idx + 1'b1;
                    state_q <= FL_SCAN;
                end
            end
        end
    end

endmodule

// File: rtl/page_cache_committer.sv
// Module: page_cache_committer (top)
// Paged write cache with a commit sequencer. Bytes of one write transaction
// load from the start offset inside cache page 0. A stop commits every
// non-empty cache page to sequential array pages, one write cycle each.
// Assumes: ADDR_W > log2(PAGE_BYTES). Strobes that arrive while busy is high
// are dropped.
module page_cache_committer #(
    parameter int PAGE_BYTES   = 8,
    parameter int NUM_PAGES    = 8,
    parameter int DATA_W       = 8,
    parameter int ADDR_W       = 13,
    parameter int WRITE_CYCLES = 16,
    localparam int OFF_W       = $clog2(PAGE_BYTES),
    localparam int IDX_W       = $clog2(NUM_PAGES),
    localparam int PAGE_AW     = ADDR_W - OFF_W
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         txn_start,
    input  logic [ADDR_W-1:0]            start_addr,
    input  logic                         byte_wr,
    input  logic [DATA_W-1:0]            byte_data,
    input  logic                         stop,
    output logic                         busy,
    output logic                         pg_req,
    output logic [PAGE_AW-1:0]           pg_addr,
    output logic [PAGE_BYTES*DATA_W-1:0] pg_data,
    output logic [PAGE_BYTES-1:0]        pg_valid
);

    logic                         acc_start;
    logic                         acc_byte;
    logic                         flush_go;
    logic                         flush_done;
    logic                         any_valid;
    logic [PAGE_AW-1:0]           base_page_q;
    logic [IDX_W-1:0]             rd_idx;
    logic [PAGE_BYTES*DATA_W-1:0] rd_data;
    logic [PAGE_BYTES-1:0]        rd_valid;

    // Input gating: no strobe is accepted during a flush.
    assign acc_start = txn_start && !busy;
    assign acc_byte  = byte_wr && !busy;
    assign flush_go  = stop && !busy && !txn_start && any_valid;

    // Start page register: holds the array page that receives cache page 0.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            base_page_q <= '0;
        end else if (acc_start) begin
            base_page_q <= start_addr[ADDR_W-1:OFF_W];
        end
    end

    pcc_store #(
        .PAGE_BYTES (PAGE_BYTES),
        .NUM_PAGES  (NUM_PAGES),
        .DATA_W     (DATA_W)
    ) u_store (
        .clk       (clk),
        .rst_n     (rst_n),
        .ld_start  (acc_start),
        .start_off (start_addr[OFF_W-1:0]),
        .ld_byte   (acc_byte),
        .ld_data   (byte_data),
        .clear_all (flush_done),
        .rd_idx    (rd_idx),
        .rd_data   (rd_data),
        .rd_valid  (rd_valid),
        .any_valid (any_valid)
    );

    pcc_flush_seq #(
        .PAGE_BYTES   (PAGE_BYTES),
        .NUM_PAGES    (NUM_PAGES),
        .DATA_W       (DATA_W),
        .PAGE_AW      (PAGE_AW),
        .WRITE_CYCLES (WRITE_CYCLES)
    ) u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .flush_go   (flush_go),
        .base_page  (base_page_q),
        .page_data  (rd_data),
        .page_valid (rd_valid),
        .idx        (rd_idx),
        .busy       (busy),
        .flush_done (flush_done),
        .pg_req     (pg_req),
        .pg_addr    (pg_addr),
        .pg_data    (pg_data),
        .pg_valid   (pg_valid)
    );

endmodule

// File: rtl/pcc_checker.sv
// Module: pcc_checker
// Protocol checks on the ports of page_cache_committer, attached by bind.
// Assumes: synchronous active-low reset and sampling at the rising edge.
module pcc_checker #(
    parameter int PAGE_BYTES = 8,
    parameter int DATA_W     = 8,
    parameter int PAGE_AW    = 10
) (
    input logic                         clk,
    input logic                         rst_n,
    input logic                         stop,
    input logic                         busy,
    input logic                         pg_req,
    input logic [PAGE_AW-1:0]           pg_addr,
    input logic [PAGE_BYTES*DATA_W-1:0] pg_data,
    input logic [PAGE_BYTES-1:0]        pg_valid
);

    // R3: a request only happens inside a flush.
    p_req_in_flush_r3: assert property (@(posedge clk) disable iff (!rst_n)
        pg_req |-> busy);

    // R3: a flush begins only after a sampled stop.
    p_busy_after_stop_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(stop));

    // R5: each request lasts one cycle.
    p_req_single_r5: assert property (@(posedge clk) disable iff (!rst_n)
        pg_req |=> !pg_req);

    // R5: an empty page never produces a request.
    p_req_nonempty_r5: assert property (@(posedge clk) disable iff (!rst_n)
        pg_req |-> (pg_valid != '0));

    // R4: the request fields change only when a request is raised.
    p_fields_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !pg_req |-> ($stable(pg_addr) && $stable(pg_data) && $stable(pg_valid)));

endmodule

bind page_cache_committer pcc_checker #(
    .PAGE_BYTES (PAGE_BYTES),
    .DATA_W     (DATA_W),
    .PAGE_AW    (PAGE_AW)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .stop     (stop),
    .busy     (busy),
    .pg_req   (pg_req),
    .pg_addr  (pg_addr),
    .pg_data  (pg_data),
    .pg_valid (pg_valid)
);

// File: tb/page_cache_committer_tb.sv
// Bench: sweeps start offsets and load lengths and computes the expected page
// requests and busy length arithmetically.
module page_cache_committer_tb;

    localparam int CLK_PERIOD = 10;
    localparam int TB_W       = 4;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        txn_start;
    logic [12:0] start_addr;
    logic        byte_wr;
    logic [7:0]  byte_data;
    logic        stop;
    logic        busy;
    logic        pg_req;
    logic [9:0]  pg_addr;
    logic [63:0] pg_data;
    logic [7:0]  pg_valid;

    int tests_run = 0;
    int tests_failed = 0;

    logic [7:0] exp_d [64];
    logic       exp_v [64];

    always #(CLK_PERIOD/2) clk = ~clk;

    page_cache_committer #(.WRITE_CYCLES(TB_W)) u_dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .txn_start  (txn_start),
        .start_addr (start_addr),
        .byte_wr    (byte_wr),
        .byte_data  (byte_data),
        .stop       (stop),
        .busy       (busy),
        .pg_req     (pg_req),
        .pg_addr    (pg_addr),
        .pg_data    (pg_data),
        .pg_valid   (pg_valid)
    );

    task automatic check(input bit ok, input string what, input logic [63:0] act,
                         input logic [63:0] exp);
        tests_run++;
        if (!ok) begin
            tests_failed++;
            $display("FAIL %s actual=%h expected=%h", what, act, exp);
        end
    endtask

    function automatic logic [7:0] pat(input int i, input int off, input int n);
        return 8'((i * 37 + off * 11 + n * 5 + 3) & 255);
    endfunction

    // One transaction: optional unflushed preload, then n bytes, stop, flush.
    task automatic run_txn(input int off, input int n, input int page,
                           input bit disturb, input bit preload);
        int   nv;
        int   cyc;
        int   reqs;
        int   cur;
        logic [63:0] ed;
        logic [7:0]  ev;
        for (int p = 0; p < 64; p++) begin exp_d[p] = 8'h00; exp_v[p] = 1'b0; end
        if (preload) begin
            txn_start = 1'b1; start_addr = 13'h1F00;
            @(negedge clk); txn_start = 1'b0;
            for (int i = 0; i < 64; i++) begin
                byte_wr = 1'b1; byte_data = 8'hC3; @(negedge clk);
            end
            byte_wr = 1'b0;
        end
        txn_start = 1'b1; start_addr = 13'((page << 3) | off);
        @(negedge clk); txn_start = 1'b0;
        for (int i = 0; i < n; i++) begin
            byte_wr = 1'b1; byte_data = pat(i, off, n);
            exp_d[(off + i) % 64] = pat(i, off, n);
            exp_v[(off + i) % 64] = 1'b1;
            @(negedge clk);
        end
        byte_wr = 1'b0;
        check(!busy && !pg_req, $sformatf("R3 idle before stop off=%0d n=%0d", off, n),
              {62'd0, busy, pg_req}, 64'd0);
        nv = 0;
        for (int k = 0; k < 8; k++) begin
            bit any = 1'b0;
            for (int j = 0; j < 8; j++) any |= exp_v[k*8+j];
            if (any) nv++;
        end
        stop = 1'b1; @(negedge clk); stop = 1'b0;
        if (n == 0) begin
            bit seen = 1'b0;
            for (int c = 0; c < 12; c++) begin
                if (busy || pg_req) seen = 1'b1;
                @(negedge clk);
            end
            check(!seen, "R8 empty stop stays idle", {63'd0, seen}, 64'd0);
            return;
        end
        cyc = 0; reqs = 0; cur = 0;
        while (busy && cyc < 2000) begin
            cyc++;
            if (pg_req) begin
                reqs++;
                while (cur < 8) begin
                    bit any = 1'b0;
                    for (int j = 0; j < 8; j++) any |= exp_v[cur*8+j];
                    if (any) break;
                    cur++;
                end
                for (int j = 0; j < 8; j++) begin
                    ed[j*8 +: 8] = exp_v[cur*8+j] ? exp_d[cur*8+j] : pg_data[j*8 +: 8];
                    ev[j]        = exp_v[cur*8+j];
                end
                check(pg_addr == 10'((page + cur) % 1024),
                      $sformatf("R2 page addr off=%0d n=%0d cpage=%0d", off, n, cur),
                      64'(pg_addr), 64'((page + cur) % 1024));
                check(pg_valid == ev && pg_data == ed,
                      $sformatf("R1/R4/R6/R7 page content off=%0d n=%0d cpage=%0d mask=%h",
                                off, n, cur, pg_valid), pg_data, ed);
                cur++;
            end
            if (disturb) begin
                byte_wr = 1'b1; byte_data = 8'h5A;
                txn_start = cyc[0]; start_addr = 13'h0005;
                stop = 1'b1;
            end
            @(negedge clk);
        end
        byte_wr = 1'b0; txn_start = 1'b0; stop = 1'b0;
        check(reqs == nv, $sformatf("R5 request count off=%0d n=%0d", off, n),
              64'(reqs), 64'(nv));
        check(cyc == 8 + nv * TB_W, $sformatf("R5 busy length off=%0d n=%0d", off, n),
              64'(cyc), 64'(8 + nv * TB_W));
        @(negedge clk);
        check(!busy && !pg_req, "R7 no restart after ignored strobes",
              {62'd0, busy, pg_req}, 64'd0);
    endtask

    initial begin
        rst_n = 1'b0; txn_start = 1'b0; start_addr = '0;
        byte_wr = 1'b0; byte_data = '0; stop = 1'b0;
        repeat (3) @(negedge clk);
        check(!busy && !pg_req, "R9 reset state", {62'd0, busy, pg_req}, 64'd0);
        rst_n = 1'b1;
        @(negedge clk);
        check(!busy && !pg_req, "R9 idle after reset", {62'd0, busy, pg_req}, 64'd0);
        for (int off = 0; off < 8; off++) begin
            for (int ni = 0; ni < 9; ni++) begin
                int lens [9] = '{0, 1, 7, 8, 9, 33, 63, 64, 65};
                int page = (ni == 5) ? 1021 : ((off * 133 + ni * 71) % 1024);
                run_txn(off, lens[ni], page, (ni % 3) == 1, 1'b0);
            end
        end
        run_txn(3, 70, 1023, 1'b1, 1'b0);
        run_txn(6, 1, 400, 1'b0, 1'b1);
        run_txn(0, 12, 17, 1'b0, 1'b1);
        $display("  [TB] %0d tests run, %0d failed", tests_run, tests_failed);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        tests_run++;
        tests_failed++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("  [TB] %0d tests run, %0d failed", tests_run, tests_failed);
        $finish;
    end

endmodule